// File: doc/BRIEF.md
# Data-Space Address Generator

This unit forms the effective data-memory address for loads and stores in a small 8-bit processor whose data space is 16 bits wide. A request names an addressing mode, a pointer (X, Y or Z), a 6-bit unsigned displacement, a full 16-bit absolute address and a read/write direction. The unit takes the current values of the three pointers from the register file. It produces the address and, for the auto-modifying modes, the updated pointer value for write-back. It also reports which region the address falls in: working registers, I/O, extended I/O or internal SRAM. It then runs a fixed two-cycle access with a single read or write strobe.

Requests enter through a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While the unit is busy, `req_ready` stays low and anything offered on the request pins is not taken. A source may hold `req_valid` high and keep the request stable until it is taken. The unit never stalls its outputs: the write-back and the strobes are single-cycle pulses that the register file and the memory must accept in that cycle. The SRAM size is set by parameter `SRAM_KB` (1, 2 or 4), so the top of SRAM is 0x04FF, 0x08FF or 0x10FF.

Top module: `dspace_agu`

## Requirements
- R1: After reset, `busy`, `mem_rd`, `mem_wr`, `wb_valid`, `addr_oor` and `mode_err` are low and `req_ready` is high.
- R2: Mode 0 (absolute) uses `req_addr` unchanged as the address, reaches all 65536 locations and does not write back.
- R3: Mode 1 (indirect) uses the selected pointer as the address. Pointer select is 0 for X, 1 for Y and 2 for Z. This mode does not write back.
- R4: Mode 2 (displacement) adds `req_disp` (0 to 63, zero-extended) to pointer Y or Z. The sum wraps modulo 65536. There is no write-back.
- R5: Mode 2 with X, pointer select 3 in modes 1 to 4, or a mode value of 5, 6 or 7 raises `mode_err` in the access cycle. Such a request drives no strobe, no write-back and no `addr_oor`.
- R6: Mode 3 (pre-decrement) uses pointer minus one as the address. It writes that same value back to the selected pointer, wrapping 0x0000 to 0xFFFF.
- R7: Mode 4 (post-increment) uses the old pointer as the address. It writes pointer plus one back, wrapping 0xFFFF to 0x0000.
- R8: `region` is 0 for 0x0000–0x001F, 1 for 0x0020–0x005F, 2 for 0x0060–0x00FF and 3 from 0x0100 up. `region_off` is the address minus the start of its region.
- R9: An address above the SRAM top raises `addr_oor` and suppresses both strobes. Write-back still happens. `region` then reads 3.
- R10: A request taken at edge k gives a computing cycle (busy, no strobe) and then an access cycle (busy, address valid). In the access cycle exactly one of `mem_rd`/`mem_wr` is high, chosen by `req_write`, unless R5 or R9 applies. After edge k+2 the unit is idle.
- R11: `req_ready` is the inverse of `busy`. A request offered while busy is ignored and does not change the access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_mode | input | 3 | Addressing mode 0–4 |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| req_disp | input | 6 | Unsigned displacement |
| req_addr | input | 16 | Absolute address |
| req_write | input | 1 | 1 store, 0 load |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| busy | output | 1 | Access in progress |
| mem_addr | output | 16 | Effective address, valid in the access cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| region | output | 2 | Region code of the address |
| region_off | output | 16 | Offset within that region |
| addr_oor | output | 1 | Address above SRAM top |
| mode_err | output | 1 | Illegal mode/pointer combination |
| wb_valid | output | 1 | Pointer write-back pulse |
| wb_sel | output | 2 | Pointer being written back |
| wb_ptr | output | 16 | New pointer value |

## Verification
The hardest conditions to reach are the wrap cases and a request that collides with an access already in flight. Wrap cases include pre-decrement from 0x0000, post-increment from 0xFFFF and a displacement carried past 0xFFFF. The bench sweeps every mode and pointer-select code, both directions, all three displacement edges and pointer values placed on every region boundary and at both ends of the space. A sweep of absolute addresses walks every location from 0 to past the SRAM top. To force a collision, the bench holds a second, different request valid through both busy cycles. It then checks that the access and write-back still match the first request and that the unit goes idle.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
  localparam int AW    = 16;
  localparam int DISPW = 6;
  localparam int SELW  = 2;
  localparam int MODEW = 3;
  localparam int RGW   = 2;

  localparam logic [MODEW-1:0] AM_DIRECT  = 3'd0;
  localparam logic [MODEW-1:0] AM_IND     = 3'd1;
  localparam logic [MODEW-1:0] AM_DISP    = 3'd2;
  localparam logic [MODEW-1:0] AM_PREDEC  = 3'd3;
  localparam logic [MODEW-1:0] AM_POSTINC = 3'd4;

  localparam logic [SELW-1:0] SEL_X = 2'd0;

  localparam logic [RGW-1:0] RG_GPR  = 2'd0;
  localparam logic [RGW-1:0] RG_IO   = 2'd1;
  localparam logic [RGW-1:0] RG_XIO  = 2'd2;
  localparam logic [RGW-1:0] RG_SRAM = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_CALC, PH_ACC} phase_e;

  typedef struct packed {
    logic [MODEW-1:0] mode;
    logic [SELW-1:0]  sel;
    logic [DISPW-1:0] disp;
    logic [AW-1:0]    dir;
    logic [AW-1:0]    base;
    logic             sel_ok;
    logic             wr;
  } req_s;
endpackage

// File: rtl/dagu_ptr_mux.sv
module dagu_ptr_mux #(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  parameter int SELW = 2
) (
  input  logic [NPTR*AW-1:0] ptr_flat,
  input  logic [SELW-1:0]    sel,
  output logic [AW-1:0]      base,
  output logic               sel_ok
);
  logic [AW-1:0] slot [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_slot
    assign slot[i] = ptr_flat[i*AW +: AW];
  end

  always_comb begin
    base   = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SELW'(i)) begin
        base   = slot[i];
        sel_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dagu_ea_calc.sv
module dagu_ea_calc
  import dagu_pkg::*;
(
  input  req_s          rq,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] new_ptr,
  output logic          wb_en,
  output logic          err
);
  logic wb_raw;

  always_comb begin
    ea      = '0;
    new_ptr = rq.base;
    wb_raw  = 1'b0;
    err     = 1'b0;
    unique case (rq.mode)
      AM_DIRECT: ea = rq.dir;
      AM_IND: begin
        ea  = rq.base;
        err = !rq.sel_ok;
      end
      AM_DISP: begin
        ea  = rq.base + AW'(rq.disp);
        err = !rq.sel_ok || (rq.sel == SEL_X);
      end
      AM_PREDEC: begin
        new_ptr = rq.base - AW'(1);
        ea      = new_ptr;
        wb_raw  = 1'b1;
        err     = !rq.sel_ok;
      end
      AM_POSTINC: begin
        ea      = rq.base;
        new_ptr = rq.base + AW'(1);
        wb_raw  = 1'b1;
        err     = !rq.sel_ok;
      end
      default: err = 1'b1;
    endcase
    wb_en = wb_raw && !err;
  end
endmodule

// File: rtl/dagu_region_dec.sv
module dagu_region_dec
  import dagu_pkg::*;
#(
  parameter int GPR_N   = 32,
  parameter int IO_N    = 64,
  parameter int XIO_N   = 160,
  parameter int SRAM_KB = 1
) (
  input  logic [AW-1:0]  ea,
  output logic [RGW-1:0] region,
  output logic [AW-1:0]  off,
  output logic           oor
);
  localparam logic [AW-1:0] IO_LO   = AW'(GPR_N);
  localparam logic [AW-1:0] XIO_LO  = AW'(GPR_N + IO_N);
  localparam logic [AW-1:0] SRAM_LO = AW'(GPR_N + IO_N + XIO_N);
  localparam int            SRAM_B  = (SRAM_KB >= 4) ? 4096 : (SRAM_KB >= 2) ? 2048 : 1024;
  localparam logic [AW-1:0] SRAM_HI = AW'(GPR_N + IO_N + XIO_N + SRAM_B - 1);

  always_comb begin
    oor = 1'b0;
    if (ea < IO_LO) begin
      region = RG_GPR;
      off    = ea;
    end else if (ea < XIO_LO) begin
      region = RG_IO;
      off    = ea - IO_LO;
    end else if (ea < SRAM_LO) begin
      region = RG_XIO;
      off    = ea - XIO_LO;
    end else begin
      region = RG_SRAM;
      off    = ea - SRAM_LO;
      oor    = (ea > SRAM_HI);
    end
  end
endmodule

// File: rtl/dagu_seq.sv
module dagu_seq
  import dagu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic take,
  output logic calc,
  output logic acc,
  output logic busy
);
  phase_e ph;

  assign req_ready = (ph == PH_IDLE);
  assign take      = req_valid && req_ready;
  assign calc      = (ph == PH_CALC);
  assign acc       = (ph == PH_ACC);
  assign busy      = !req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_IDLE;
    else begin
      unique case (ph)
        PH_IDLE: if (take) ph <= PH_CALC;
        PH_CALC: ph <= PH_ACC;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_busy_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_acc_follows_calc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    calc |=> acc);
  p_acc_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !busy);
  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && calc) |=> acc);
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import dagu_pkg::*;
#(
  parameter int SRAM_KB = 1,
  parameter int NPTR    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MODEW-1:0] req_mode,
  input  logic [SELW-1:0]  req_ptr,
  input  logic [DISPW-1:0] req_disp,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [AW-1:0]    ptr_x,
  input  logic [AW-1:0]    ptr_y,
  input  logic [AW-1:0]    ptr_z,
  output logic             busy,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [RGW-1:0]   region,
  output logic [AW-1:0]    region_off,
  output logic             addr_oor,
  output logic             mode_err,
  output logic             wb_valid,
  output logic [SELW-1:0]  wb_sel,
  output logic [AW-1:0]    wb_ptr
);
  logic take, calc, acc;
  logic [NPTR*AW-1:0] ptr_flat;
  logic [AW-1:0] base_now;
  logic sel_ok_now;
  req_s rq_q;

  logic [AW-1:0]  ea, nptr;
  logic           wb_en, err;
  logic [RGW-1:0] rg;
  logic [AW-1:0]  rg_off;
  logic           oor;

  logic           oor_q, err_q, wb_en_q, wr_q;
  logic [MODEW-1:0] mode_q;

  assign ptr_flat = {ptr_z, ptr_y, ptr_x};

  dagu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .take(take), .calc(calc), .acc(acc), .busy(busy)
  );

  dagu_ptr_mux #(.AW(AW), .NPTR(NPTR), .SELW(SELW)) u_mux (
    .ptr_flat(ptr_flat), .sel(req_ptr), .base(base_now), .sel_ok(sel_ok_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rq_q <= '0;
    else if (take) begin
      rq_q.mode   <= req_mode;
      rq_q.sel    <= req_ptr;
      rq_q.disp   <= req_disp;
      rq_q.dir    <= req_addr;
      rq_q.base   <= base_now;
      rq_q.sel_ok <= sel_ok_now;
      rq_q.wr     <= req_write;
    end
  end

  dagu_ea_calc u_ea (
    .rq(rq_q), .ea(ea), .new_ptr(nptr), .wb_en(wb_en), .err(err)
  );

  dagu_region_dec #(.SRAM_KB(SRAM_KB)) u_dec (
    .ea(ea), .region(rg), .off(rg_off), .oor(oor)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      region     <= RG_GPR;
      region_off <= '0;
      oor_q      <= 1'b0;
      err_q      <= 1'b0;
      wb_en_q    <= 1'b0;
      wr_q       <= 1'b0;
      wb_sel     <= '0;
      wb_ptr     <= '0;
      mode_q     <= AM_DIRECT;
    end else if (calc) begin
      mem_addr   <= ea;
      region     <= rg;
      region_off <= rg_off;
      oor_q      <= oor;
      err_q      <= err;
      wb_en_q    <= wb_en;
      wr_q       <= rq_q.wr;
      wb_sel     <= rq_q.sel;
      wb_ptr     <= nptr;
      mode_q     <= rq_q.mode;
    end
  end

  assign mode_err = acc && err_q;
  assign addr_oor = acc && oor_q && !err_q;
  assign wb_valid = acc && wb_en_q;
  assign mem_rd   = acc && !err_q && !oor_q && !wr_q;
  assign mem_wr   = acc && !err_q && !oor_q && wr_q;

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (busy && $past(busy)));
  p_oor_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oor |-> (!mem_rd && !mem_wr));
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!mem_rd && !mem_wr && !wb_valid && !addr_oor));
  p_wb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  p_predec_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && mode_q == AM_PREDEC) |-> (wb_ptr == mem_addr));
  p_postinc_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && mode_q == AM_POSTINC) |-> (wb_ptr == mem_addr + AW'(1)));
  p_sram_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oor |-> (region == RG_SRAM));
endmodule

// File: tb/tb_dspace_agu.sv
`timescale 1ns/1ps
module tb_dspace_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_ptr = '0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_addr = '0, ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        busy, mem_rd, mem_wr, addr_oor, mode_err, wb_valid;
  logic [15:0] mem_addr, region_off, wb_ptr;
  logic [1:0]  region, wb_sel;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  dspace_agu #(.SRAM_KB(1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_ptr(req_ptr), .req_disp(req_disp), .req_addr(req_addr),
    .req_write(req_write), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .region(region), .region_off(region_off), .addr_oor(addr_oor),
    .mode_err(mode_err), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_ptr(wb_ptr)
  );

  localparam logic [15:0] TOP = 16'h04FF;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R5";
    endcase
  endfunction

  // one transaction; ov_* is a different request held valid while busy (R11)
  task automatic run(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                     input logic [15:0] a, input logic w, input bit overlap);
    logic [15:0] base, ea, np;
    bit err, wbx, oor;
    logic [1:0] rgn;
    logic [15:0] off;
    string t;
    base = (s == 2'd0) ? ptr_x : (s == 2'd1) ? ptr_y : ptr_z;
    err = 1'b0; wbx = 1'b0; np = base; ea = 16'h0;
    case (m)
      3'd0: ea = a;
      3'd1: begin ea = base; err = (s == 2'd3); end
      3'd2: begin ea = base + {10'd0, d}; err = (s == 2'd3) || (s == 2'd0); end
      3'd3: begin np = base - 16'd1; ea = np; wbx = 1'b1; err = (s == 2'd3); end
      3'd4: begin np = base + 16'd1; ea = base; wbx = 1'b1; err = (s == 2'd3); end
      default: err = 1'b1;
    endcase
    if (ea < 16'h0020) begin rgn = 2'd0; off = ea; end
    else if (ea < 16'h0060) begin rgn = 2'd1; off = ea - 16'h0020; end
    else if (ea < 16'h0100) begin rgn = 2'd2; off = ea - 16'h0060; end
    else begin rgn = 2'd3; off = ea - 16'h0100; end
    oor = (ea > TOP);
    t = mode_tag(m);
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready when idle", req_ready, 1);
    req_mode = m; req_ptr = s; req_disp = d; req_addr = a; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1 && req_ready === 1'b0, "R11", "busy in compute cycle", busy, 1);
    chk(!mem_rd && !mem_wr && !wb_valid, "R10", "no strobe in compute cycle",
        {mem_rd, mem_wr, wb_valid}, 0);
    if (overlap) begin
      req_mode = 3'd0; req_addr = ~ea; req_write = ~w; req_ptr = s ^ 2'd1;
    end else req_valid = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R10", "busy in access cycle", busy, 1);
    chk(mode_err === err, "R5", "mode_err", mode_err, err);
    if (!err) begin
      chk(mem_addr === ea, t, "address", mem_addr, ea);
      chk(region === rgn, "R8", "region", region, rgn);
      chk(region_off === off, "R8", "offset", region_off, off);
      chk(addr_oor === oor, "R9", "oor flag", addr_oor, oor);
      chk(mem_rd === (!oor && !w), (oor ? "R9" : "R10"), "read strobe", mem_rd, !oor && !w);
      chk(mem_wr === (!oor && w), (oor ? "R9" : "R10"), "write strobe", mem_wr, !oor && w);
    end else begin
      chk(!mem_rd && !mem_wr && !addr_oor, "R5", "quiet on error",
          {mem_rd, mem_wr, addr_oor}, 0);
    end
    chk(wb_valid === (wbx && !err), t, "wb_valid", wb_valid, wbx && !err);
    if (wbx && !err) begin
      chk(wb_ptr === np, t, "wb_ptr", wb_ptr, np);
      chk(wb_sel === s, t, "wb_sel", wb_sel, s);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr && !wb_valid, "R10", "idle after access",
        {busy, mem_rd, mem_wr, wb_valid}, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pv [10];
    logic [5:0]  dv [3];
    pv = '{16'h0000, 16'h0001, 16'h001F, 16'h0020, 16'h005F,
           16'h00FF, 16'h0100, 16'h04FF, 16'h8000, 16'hFFFF};
    dv = '{6'd0, 6'd1, 6'd63};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && req_ready && !mem_rd && !mem_wr && !wb_valid && !addr_oor && !mode_err,
        "R1", "reset outputs", {busy, mem_rd, mem_wr, wb_valid, addr_oor, mode_err}, 0);
    rst_n = 1'b1;
    // full mode / pointer / direction sweep
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 10; p++)
          for (int di = 0; di < 3; di++)
            for (int w = 0; w < 2; w++) begin
              ptr_x = pv[p]; ptr_y = pv[p] + 16'd3; ptr_z = pv[p] + 16'd7;
              run(3'(m), 2'(s), dv[di], pv[(p + di) % 10], 1'(w), 1'b0);
            end
    // R8 / R9 absolute walk across every region up past SRAM top
    for (int a = 0; a < 16'h0510; a++) run(3'd0, 2'd0, 6'd0, 16'(a), 1'(a & 1), 1'b0);
    run(3'd0, 2'd0, 6'd0, 16'hFFFF, 1'b1, 1'b0);
    // R11 second request held while busy, every legal mode
    for (int m = 0; m < 5; m++) begin
      ptr_x = 16'h0200; ptr_y = 16'hFFF0; ptr_z = 16'h0000;
      run(3'(m), 2'd2, 6'd20, 16'h0321, 1'b0, 1'b1);
      run(3'(m), 2'd1, 6'd63, 16'h0050, 1'b1, 1'b1);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule